// File: doc/BRIEF.md
# Up-Counting Timer with Trigger-Driven Restart

This block is a general-purpose up-counter driven by a programmable clock divider, with a slave controller that can restart it from an external pin. The trigger is taken from input pin 1 or from the exclusive-OR of pins 1, 2 and 3. It passes through a two-flop synchronizer and an edge selector that accepts rising edges, falling edges or both. When the controller is in its restart mode and the pin path is the chosen source, each accepted edge zeroes both the counter and its divider. It also raises a sticky trigger flag, and it can request an interrupt or a DMA transfer.

The wrap limit and compare value are written into preload registers. They reach the active copies only on an update event. An update event happens when the counter wraps, or on a trigger when the control word allows triggers to act as updates. Software programs the block through a single-cycle write port and watches the counter, the flags and the request lines.

Top module: `trig_reset_timer`

## Requirements
- R1: After reset, cnt_o is 0 and upd_flag_o, trig_flag_o, irq_o, dma_req_o and cmp_hit_o are all 0. The counter holds its value while the run bit (address 0, bit 0) is 0.
- R2: With the run bit set and a divide value P written at address 4, the counter advances once every P+1 clocks. Once it equals the active wrap limit, its next advance returns it to 0 and sets the update flag (upd_flag_o, status bit 0).
- R3: Set the mode field (address 1 bits 2:0) to 3'b100 and the source field (address 1 bits 6:4) to 3'b101. An accepted edge then sets cnt_o to 0 after the third rising clock edge following the pin change, and counting resumes from 0. With the run bit at 0, the counter stays at 0.
- R4: A trigger also zeroes the divider, so the first advance after a trigger comes exactly P+1 clocks after the clear.
- R5: The trigger flag (trig_flag_o, status bit 1) is set by every accepted trigger. It stays set until a write to address 3 carries 0 in bit 1; writing 1 there leaves it set. A trigger in the same cycle as the clearing write leaves it set. Writing 0 to bit 0 clears the update flag in the same way.
- R6: irq_o is high when (trigger flag AND address 2 bit 0) or (update flag AND address 2 bit 2). If address 2 bit 1 is set, dma_req_o pulses high for one clock with each accepted trigger.
- R7: With address 0 bit 1 at 0, a trigger is also an update event: it copies the preloads into the active registers and sets the update flag. With that bit at 1, a trigger does neither.
- R8: Address 1 bit 9 set accepts both pin edges. Otherwise, bit 8 set accepts only falling edges and bit 8 clear accepts only rising edges.
- R9: With address 0 bit 2 set, the trigger path sees pin1 XOR pin2 XOR pin3. With it clear, pins 2 and 3 have no effect.
- R10: Pin edges neither clear the counter nor set the trigger flag when the mode field is not 3'b100 or the source field is not 3'b101.
- R11: Writes to the wrap-limit preload (address 5) and compare preload (address 6) take effect only at the next update event. Both active registers reset to all ones.
- R12: cmp_hit_o is high exactly while cnt_o equals the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| tin1 | input | 1 | Timer input pin 1 |
| tin2 | input | 1 | Timer input pin 2 |
| tin3 | input | 1 | Timer input pin 3 |
| cnt_o | output | 16 | Current counter value |
| cmp_hit_o | output | 1 | Counter equals active compare value |
| upd_flag_o | output | 1 | Sticky update flag |
| trig_flag_o | output | 1 | Sticky trigger flag |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | One-clock DMA request per trigger |

## Verification
A divider phase left over after a trigger shows at cnt_o one to P clocks early, on the first advance. A stale active wrap limit shows as cnt_o running past the new limit or wrapping early within one count period. A synchronizer with the wrong depth moves the clear and the flag by whole clocks, so checks at exactly the second and third edge after a pin change catch it. A missing preload or update path shows as a wrong upd_flag_o or cmp_hit_o in the first counting period after the trigger.

// File: rtl/trig_reset_timer_pkg.sv
package trig_reset_timer_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SLAVE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV    = 3'd4;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd5;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd6;

  localparam logic [2:0] MODE_RESTART = 3'b100;
  localparam logic [2:0] SRC_PIN1     = 3'b101;

  typedef struct packed {
    logic       run;
    logic       ovf_only;
    logic       xor_sel;
    logic [2:0] mode;
    logic [2:0] src;
    logic       inv;
    logic       both;
    logic       ie_trig;
    logic       de_trig;
    logic       ie_upd;
  } cfg_t;

endpackage

// File: rtl/trig_reset_timer_regs.sv
module trig_reset_timer_regs
  import trig_reset_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic [DIV_W-1:0]  div_val,
  output logic [CNT_W-1:0]  reload_pre,
  output logic [CNT_W-1:0]  cmp_pre,
  output logic              clr_upd,
  output logic              clr_trig
);

  cfg_t             cfg_q, cfg_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] rel_q, rel_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             stat_wr;

  assign stat_wr = wr_en && (wr_addr == A_STAT);

  always_comb begin
    cfg_d = cfg_q;
    div_d = div_q;
    rel_d = rel_q;
    cmp_d = cmp_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          cfg_d.run      = wr_data[0];
          cfg_d.ovf_only = wr_data[1];
          cfg_d.xor_sel  = wr_data[2];
        end
        A_SLAVE: begin
          cfg_d.mode = wr_data[2:0];
          cfg_d.src  = wr_data[6:4];
          cfg_d.inv  = wr_data[8];
          cfg_d.both = wr_data[9];
        end
        A_IEN: begin
          cfg_d.ie_trig = wr_data[0];
          cfg_d.de_trig = wr_data[1];
          cfg_d.ie_upd  = wr_data[2];
        end
        A_DIV:    div_d = wr_data[DIV_W-1:0];
        A_RELOAD: rel_d = wr_data[CNT_W-1:0];
        A_CMP:    cmp_d = wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
      rel_q <= '1;
      cmp_q <= '1;
    end else begin
      cfg_q <= cfg_d;
      div_q <= div_d;
      rel_q <= rel_d;
      cmp_q <= cmp_d;
    end
  end

  assign cfg        = cfg_q;
  assign div_val    = div_q;
  assign reload_pre = rel_q;
  assign cmp_pre    = cmp_q;
  assign clr_upd    = stat_wr && !wr_data[0];
  assign clr_trig   = stat_wr && !wr_data[1];

endmodule

// File: rtl/trig_reset_timer_edge.sv
module trig_reset_timer_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin1,
  input  logic pin2,
  input  logic pin3,
  input  logic xor_sel,
  input  logic inv,
  input  logic both,
  output logic edge_hit
);

  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q;
  logic                   cur, rise, fall;

  assign raw = xor_sel ? (pin1 ^ pin2 ^ pin3) : pin1;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = raw;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], raw};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= cur;
    end
  end

  assign cur  = sync_q[SYNC_STAGES-1];
  assign rise = cur & ~last_q;
  assign fall = ~cur & last_q;

  always_comb begin
    if (both)     edge_hit = rise | fall;
    else if (inv) edge_hit = fall;
    else          edge_hit = rise;
  end

endmodule

// File: rtl/trig_reset_timer_core.sv
module trig_reset_timer_core #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ovf_only,
  input  logic             trig,
  input  logic [DIV_W-1:0] div_val,
  input  logic [CNT_W-1:0] reload_pre,
  input  logic [CNT_W-1:0] cmp_pre,
  output logic [CNT_W-1:0] cnt,
  output logic             cmp_hit,
  output logic             upd_evt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] pc_q, pc_d;
  logic [CNT_W-1:0] rel_act_q, rel_act_d;
  logic [CNT_W-1:0] cmp_act_q, cmp_act_d;
  logic             div_tc, wrap;

  assign div_tc = run && (pc_q >= div_val);
  assign wrap   = div_tc && (cnt_q == rel_act_q);

  always_comb begin
    cnt_d     = cnt_q;
    pc_d      = pc_q;
    rel_act_d = rel_act_q;
    cmp_act_d = cmp_act_q;
    upd_evt   = trig ? !ovf_only : wrap;
    if (trig) begin
      cnt_d = '0;
      pc_d  = '0;
    end else if (run) begin
      if (div_tc) begin
        pc_d  = '0;
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end else begin
        pc_d = pc_q + 1'b1;
      end
    end
    if (upd_evt) begin
      rel_act_d = reload_pre;
      cmp_act_d = cmp_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pc_q      <= '0;
      rel_act_q <= '1;
      cmp_act_q <= '1;
    end else begin
      cnt_q     <= cnt_d;
      pc_q      <= pc_d;
      rel_act_q <= rel_act_d;
      cmp_act_q <= cmp_act_d;
    end
  end

  assign cnt     = cnt_q;
  assign cmp_hit = (cnt_q == cmp_act_q);

endmodule

// File: rtl/trig_reset_timer_flags.sv
module trig_reset_timer_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic upd_evt,
  input  logic clr_trig,
  input  logic clr_upd,
  input  logic ie_trig,
  input  logic de_trig,
  input  logic ie_upd,
  output logic trig_flag,
  output logic upd_flag,
  output logic irq,
  output logic dma_req
);

  logic tf_q, tf_d;
  logic uf_q, uf_d;
  logic dma_q, dma_d;

  always_comb begin
    tf_d  = trig ? 1'b1 : (clr_trig ? 1'b0 : tf_q);
    uf_d  = upd_evt ? 1'b1 : (clr_upd ? 1'b0 : uf_q);
    dma_d = trig && de_trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf_q  <= 1'b0;
      uf_q  <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      tf_q  <= tf_d;
      uf_q  <= uf_d;
      dma_q <= dma_d;
    end
  end

  assign trig_flag = tf_q;
  assign upd_flag  = uf_q;
  assign dma_req   = dma_q;
  assign irq       = (tf_q && ie_trig) || (uf_q && ie_upd);

endmodule

// File: rtl/trig_reset_timer.sv
module trig_reset_timer
  import trig_reset_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tin1,
  input  logic              tin2,
  input  logic              tin3,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cmp_hit_o,
  output logic              upd_flag_o,
  output logic              trig_flag_o,
  output logic              irq_o,
  output logic              dma_req_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  cfg_t             cfg;
  logic [DIV_W-1:0] div_val;
  logic [CNT_W-1:0] reload_pre, cmp_pre;
  logic             clr_upd, clr_trig;
  logic             edge_hit, trig_ok, upd_evt;
  logic             run_en, ovf_only;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  trig_reset_timer_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .div_val(div_val),
    .reload_pre(reload_pre), .cmp_pre(cmp_pre),
    .clr_upd(clr_upd), .clr_trig(clr_trig)
  );

  trig_reset_timer_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin1(tin1), .pin2(tin2), .pin3(tin3),
    .xor_sel(cfg.xor_sel), .inv(cfg.inv), .both(cfg.both),
    .edge_hit(edge_hit)
  );

  assign trig_ok  = edge_hit && (cfg.mode == MODE_RESTART) && (cfg.src == SRC_PIN1);
  assign run_en   = cfg.run;
  assign ovf_only = cfg.ovf_only;

  trig_reset_timer_core #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .run(run_en), .ovf_only(ovf_only),
    .trig(trig_ok), .div_val(div_val), .reload_pre(reload_pre),
    .cmp_pre(cmp_pre), .cnt(cnt_o), .cmp_hit(cmp_hit_o), .upd_evt(upd_evt)
  );

  trig_reset_timer_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n), .trig(trig_ok), .upd_evt(upd_evt),
    .clr_trig(clr_trig), .clr_upd(clr_upd), .ie_trig(cfg.ie_trig),
    .de_trig(cfg.de_trig), .ie_upd(cfg.ie_upd), .trig_flag(trig_flag_o),
    .upd_flag(upd_flag_o), .irq(irq_o), .dma_req(dma_req_o)
  );

endmodule

// File: rtl/trig_reset_timer_chk.sv
module trig_reset_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_ok,
  input logic             run,
  input logic             ovf_only,
  input logic [CNT_W-1:0] cnt,
  input logic             trig_flag,
  input logic             upd_flag,
  input logic             dma_req,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [15:0]      wr_data
);

  logic trig_clr_wr;
  assign trig_clr_wr = wr_en && (wr_addr == 3'd3) && !wr_data[1];

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !trig_ok) |=> $stable(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |=> (cnt == '0));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |=> trig_flag);

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_flag && !trig_clr_wr) |=> trig_flag);

  p_dma_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(trig_ok));

  p_upd_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ok && !ovf_only) |=> upd_flag);

  p_flag_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_flag) |-> $past(trig_ok));

endmodule

bind trig_reset_timer trig_reset_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .trig_ok(trig_ok), .run(run_en),
  .ovf_only(ovf_only), .cnt(cnt_o), .trig_flag(trig_flag_o),
  .upd_flag(upd_flag_o), .dma_req(dma_req_o), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/trig_reset_timer_bench.sv
`timescale 1ns/1ps
module trig_reset_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        tin1, tin2, tin3;
  logic [15:0] cnt_o;
  logic        cmp_hit_o, upd_flag_o, trig_flag_o, irq_o, dma_req_o;

  int checks = 0;
  int errors = 0;
  int kk = 0;
  int P = 0;
  int R = 0;
  int C = 0;

  always #2 clk = ~clk;

  trig_reset_timer u_trig_reset_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tin1(tin1), .tin2(tin2), .tin3(tin3),
    .cnt_o(cnt_o), .cmp_hit_o(cmp_hit_o), .upd_flag_o(upd_flag_o),
    .trig_flag_o(trig_flag_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      kk++;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    tick(1);
    wr_en   = 1'b0;
  endtask

  function automatic int exp_cnt();
    return (kk / (P + 1)) % (R + 1);
  endfunction

  // drive pin 1 high from low and stop right after the third edge
  task automatic fire_rise();
    tin1 = 1'b0;
    tick(4);
    tin1 = 1'b1;
    tick(3);
    kk = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tin1 = 1'b0; tin2 = 1'b0; tin3 = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk(cnt_o == 0, "R1 cnt", cnt_o, 0);
    chk(!upd_flag_o && !trig_flag_o, "R1 flags", {upd_flag_o, trig_flag_o}, 0);
    chk(!irq_o && !dma_req_o, "R1 requests", {irq_o, dma_req_o}, 0);
    chk(!cmp_hit_o, "R1 cmp_hit", cmp_hit_o, 0);
    wr(3'd1, 16'h0054);
    wr(3'd2, 16'h0000);
    tick(5);
    chk(cnt_o == 0, "R1 idle while run clear", cnt_o, 0);

    // R2 R4 R7 R11 R12 sweep over divide and wrap settings
    for (int cfg_i = 0; cfg_i < 5; cfg_i++) begin
      case (cfg_i)
        0: begin P = 0; R = 5; end
        1: begin P = 1; R = 5; end
        2: begin P = 2; R = 3; end
        3: begin P = 3; R = 2; end
        default: begin P = 0; R = 54; end
      endcase
      C = R / 2;
      wr(3'd4, 16'(P));
      wr(3'd5, 16'(R));
      wr(3'd6, 16'(C));
      wr(3'd0, 16'h0001);
      fire_rise();
      chk(cnt_o == 0, "R3 clear", cnt_o, 0);
      chk(upd_flag_o, "R7 trigger update", upd_flag_o, 1);
      chk(trig_flag_o, "R5 set", trig_flag_o, 1);
      wr(3'd0, 16'h0003);
      tin1 = 1'b0;
      tick(4);
      tin1 = 1'b1;
      tick(2);
      wr(3'd3, 16'h0000);
      kk = 0;
      chk(trig_flag_o, "R5 set wins over clear", trig_flag_o, 1);
      chk(!upd_flag_o, "R7 no update when bit1 set", upd_flag_o, 0);
      chk(!dma_req_o, "R6 no dma when disabled", dma_req_o, 0);
      tin1 = 1'b0;
      while (kk <= 2 * (R + 1) * (P + 1) + 1) begin
        chk(cnt_o == exp_cnt(), "R2 R4 count", cnt_o, exp_cnt());
        chk(upd_flag_o == (kk >= (R + 1) * (P + 1)), "R2 wrap flag",
            upd_flag_o, kk >= (R + 1) * (P + 1));
        chk(cmp_hit_o == (exp_cnt() == C), "R12 cmp_hit", cmp_hit_o, exp_cnt() == C);
        chk(!irq_o, "R6 irq masked", irq_o, 0);
        tick(1);
      end
    end

    // R3 latency: flag rises after the third edge, not the second
    wr(3'd3, 16'h0000);
    tin1 = 1'b1;
    tick(2);
    chk(!trig_flag_o, "R3 not after second edge", trig_flag_o, 0);
    tick(1);
    kk = 0;
    chk(trig_flag_o && cnt_o == 0, "R3 after third edge", cnt_o, 0);

    // R6 interrupt and DMA
    wr(3'd2, 16'h0003);
    wr(3'd3, 16'h0000);
    fire_rise();
    chk(dma_req_o, "R6 dma pulse", dma_req_o, 1);
    chk(irq_o, "R6 trig irq", irq_o, 1);
    tick(1);
    chk(!dma_req_o, "R6 dma one clock", dma_req_o, 0);
    chk(irq_o, "R6 irq held", irq_o, 1);
    wr(3'd3, 16'h0002);
    chk(trig_flag_o, "R5 writing one keeps flag", trig_flag_o, 1);
    wr(3'd3, 16'h0000);
    chk(!trig_flag_o && !irq_o, "R5 R6 clear", {trig_flag_o, irq_o}, 0);
    wr(3'd2, 16'h0004);
    tick(54 - kk);
    chk(!irq_o && !upd_flag_o, "R6 no update irq before wrap", irq_o, 0);
    tick(2);
    chk(irq_o && upd_flag_o, "R6 update irq", irq_o, 1);
    wr(3'd2, 16'h0000);

    // R7 R11 preload timing
    wr(3'd5, 16'd3);
    wr(3'd3, 16'h0000);
    fire_rise();
    chk(!upd_flag_o, "R7 bit1 set blocks update", upd_flag_o, 0);
    tick(10);
    chk(cnt_o == 10, "R11 preload not yet active", cnt_o, 10);
    wr(3'd0, 16'h0001);
    fire_rise();
    chk(upd_flag_o && cnt_o == 0, "R7 trigger loads", upd_flag_o, 1);
    tick(3);
    chk(cnt_o == 3, "R11 new limit reached", cnt_o, 3);
    tick(1);
    chk(cnt_o == 0, "R11 new limit wraps", cnt_o, 0);

    // R8 polarity
    wr(3'd1, 16'h0154);
    tick(4);
    wr(3'd3, 16'h0000);
    tin1 = 1'b0;
    tick(3);
    chk(trig_flag_o && cnt_o == 0, "R8 falling accepted", trig_flag_o, 1);
    wr(3'd3, 16'h0000);
    tin1 = 1'b1;
    tick(4);
    chk(!trig_flag_o, "R8 rising ignored", trig_flag_o, 1'b0);
    wr(3'd1, 16'h0354);
    wr(3'd3, 16'h0000);
    tin1 = 1'b0;
    tick(3);
    chk(trig_flag_o, "R8 both falling", trig_flag_o, 1);
    wr(3'd3, 16'h0000);
    tin1 = 1'b1;
    tick(3);
    chk(trig_flag_o, "R8 both rising", trig_flag_o, 1);

    // R9 three-pin XOR
    wr(3'd1, 16'h0054);
    wr(3'd0, 16'h0005);
    tick(4);
    wr(3'd3, 16'h0000);
    tin3 = 1'b1;
    tick(4);
    chk(!trig_flag_o, "R9 xor falling ignored", trig_flag_o, 0);
    tin2 = 1'b1;
    tick(3);
    chk(trig_flag_o && cnt_o == 0, "R9 xor rising", trig_flag_o, 1);
    wr(3'd0, 16'h0001);
    tick(4);
    wr(3'd3, 16'h0000);
    tin2 = 1'b0;
    tick(4);
    tin2 = 1'b1;
    tick(4);
    chk(!trig_flag_o, "R9 pin2 ignored without xor", trig_flag_o, 0);

    // R10 other mode or source ignored, counter frozen
    wr(3'd5, 16'd54);
    fire_rise();
    tick(5);
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0000);
    chk(cnt_o == 6, "R1 frozen value", cnt_o, 6);
    wr(3'd1, 16'h0050);
    fire_rise();
    tick(1);
    chk(!trig_flag_o && cnt_o == 6, "R10 mode off", cnt_o, 6);
    wr(3'd1, 16'h0064);
    fire_rise();
    tick(1);
    chk(!trig_flag_o && cnt_o == 6, "R10 other source", cnt_o, 6);
    wr(3'd1, 16'h0054);
    fire_rise();
    chk(trig_flag_o && cnt_o == 0, "R3 clear while stopped", cnt_o, 0);
    tick(3);
    chk(cnt_o == 0, "R1 stays zero while stopped", cnt_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule